// File: doc/BRIEF.md
# Service-Request Mailbox Register Interface

This block is the host-facing side of a command mailbox between a host processor and a system-controller service engine. It decodes a small register window: a control register, a status register, an interrupt-clear register and a word-addressed shared RAM. The host first places command data in the RAM. It then writes the control register with a 7-bit opcode, a RAM word offset, the request bit and, when it wants an interrupt, the notify bit.

While the service runs, the status register reports busy. A service-engine stub stands in for the real engine. It reads the first command word at the offset and waits a parameterised number of cycles. It then writes a fixed number of response words, each derived from the opcode and that command word, back into the RAM starting at the same offset. When the last response word is written, busy drops and, if notify was asked for, the interrupt output rises. Any write to the interrupt-clear register lowers the interrupt. While busy, the host can cancel the service by writing the abort bit.

Both the registers and the RAM answer a read one cycle after it is issued. Partial command words are merged by the host with read-modify-write, so the RAM returns exactly what was last written to it.

Top module: `svc_mailbox`

## Requirements
- R1: After reset the control and status registers read 0x0000_0000 and `irq` is low.
- R2: The RAM is reached at byte address 0x800 + 4*i for word i (i from 0 to RAM_WORDS-1). A write stores all 32 bits. A read returns the last value written, on `bus_rdata`, in the cycle after the read strobe.
- R3: Bit positions are the same in the control register (0x50) and the status register (0x54): bit 0 request, bit 1 busy, bit 2 abort, bit 3 notify. Bits [22:16] hold the opcode and bits [31:23] hold the RAM word offset; the offset is taken modulo RAM_WORDS. Both registers read back the field latched at the last accepted request. The control register reads back the notify enable in bit 3. The status register reports the pending interrupt in bit 3.
- R4: A control write with bit 0 set while not busy is accepted. The status register then shows request=1 and busy=1 for exactly one read cycle, and request=0 with busy=1 after that.
- R5: An accepted service writes RESP_WORDS response words. Word k goes to RAM word (offset+k) mod RAM_WORDS. Its value is C ^ {k[7:0], 1'b0, opcode[6:0], 16'h5A5A}, where C is the RAM word at the offset when the service started. Busy clears in the cycle the last word is written. No other RAM word is changed.
- R6: At completion `irq` rises and status bit 3 is set only if bit 3 was set in the accepted request. Otherwise `irq` stays low.
- R7: Any write to the interrupt-clear register at byte 0x58 lowers `irq` and status bit 3.
- R8: A control write with bit 2 set while busy ends the service at once. The next status read shows busy=0 and abort=1. No response word is written and `irq` does not rise.
- R9: A control write with bit 0 set while busy is ignored. The latched opcode and offset are unchanged, and the running service completes with its original command.
- R10: A control write with bit 2 set while idle has no effect. The abort status bit stays set until the next accepted request clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Completion interrupt, level |

## Verification
The bench samples the status register in the first two cycles after a request, to catch a request bit that lingers or never appears. It issues a second request while the first is running; a design that accepted it would overwrite the opcode and produce responses with the wrong pattern. It aborts mid-service and checks that the response window and the interrupt stay untouched, which a design that let the stub finish would fail. It places a command near the top of the RAM, so a design that does not wrap the response index would corrupt or miss the words that wrap back to word 0.

// File: rtl/svc_mbox_pkg.sv
// Package: shared offsets, bit positions, state type and response rule
// for the service-request mailbox. Assumes a 32-bit data bus.
package svc_mbox_pkg;

    localparam int DATA_W      = 32;

    // Byte offsets within the register window
    localparam int CTRL_OFS    = 'h050;
    localparam int STAT_OFS    = 'h054;
    localparam int IRQCLR_OFS  = 'h058;
    localparam int RAM_BASE    = 'h800;

    // Bit positions shared by control and status words
    localparam int BIT_REQ     = 0;
    localparam int BIT_BUSY    = 1;
    localparam int BIT_ABORT   = 2;
    localparam int BIT_NOTIFY  = 3;

    // Command field in the upper half-word
    localparam int FIELD_LSB   = 16;
    localparam int FIELD_W     = 16;
    localparam int OP_W        = 7;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_FETCH,
        ENG_RUN,
        ENG_WRITE
    } eng_state_e;

    // Response word k of a service, derived from the first command word
    function automatic logic [DATA_W-1:0] resp_word(
        input logic [DATA_W-1:0] cmd0,
        input logic [OP_W-1:0]   op,
        input logic [7:0]        k
    );
        return cmd0 ^ {k, 1'b0, op, 16'h5A5A};
    endfunction

endpackage

// File: rtl/svc_mbox_ram.sv
// Shared mailbox RAM: WORDS x 32, one host port and one engine port,
// each with a synchronous read. Assumes the two ports never write the
// same word in the same cycle; if they do, the engine write wins.
module svc_mbox_ram #(
    parameter int WORDS = 64,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              h_we,
    input  logic              h_re,
    input  logic [IDX_W-1:0]  h_idx,
    input  logic [31:0]       h_wdata,
    output logic [31:0]       h_rdata,
    input  logic              e_we,
    input  logic              e_re,
    input  logic [IDX_W-1:0]  e_idx,
    input  logic [31:0]       e_wdata,
    output logic [31:0]       e_rdata
);

    logic [31:0] mem [WORDS];

    // Storage writes, engine last so it takes priority on a clash
    always_ff @(posedge clk) begin
        if (h_we) begin
            mem[h_idx] <= h_wdata;
        end
        if (e_we) begin
            mem[e_idx] <= e_wdata;
        end
    end

    // Host-port registered read
    always_ff @(posedge clk) begin
        if (h_re) begin
            h_rdata <= mem[h_idx];
        end
    end

    // Engine-port registered read
    always_ff @(posedge clk) begin
        if (e_re) begin
            e_rdata <= mem[e_idx];
        end
    end

endmodule

// File: rtl/svc_mbox_engine.sv
// Service-engine stub. On start it reads the command word at the given
// offset, waits SVC_CYCLES cycles, then writes RESP_WORDS response words
// at offset, offset+1, ... (wrapping in the RAM). An abort returns it to
// idle at once with no further writes and no done pulse.
// Assumes SVC_CYCLES >= 1 and 1 <= RESP_WORDS <= WORDS.
module svc_mbox_engine
    import svc_mbox_pkg::*;
#(
    parameter int WORDS      = 64,
    parameter int SVC_CYCLES = 8,
    parameter int RESP_WORDS = 4,
    localparam int IDX_W = $clog2(WORDS),
    localparam int CNT_W = $clog2(SVC_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [OP_W-1:0]   op,
    input  logic [IDX_W-1:0]  ofs,
    output logic              e_re,
    output logic              e_we,
    output logic [IDX_W-1:0]  e_idx,
    output logic [31:0]       e_wdata,
    input  logic [31:0]       e_rdata,
    output logic              done
);

    localparam logic [IDX_W-1:0] LAST_W  = IDX_W'(RESP_WORDS - 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(SVC_CYCLES - 1);

    eng_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  widx;
    logic [IDX_W-1:0]  base_q;
    logic [OP_W-1:0]   op_q;
    logic [31:0]       cmd0_q;
    logic              last_w;

    assign last_w = (widx == LAST_W);

    // RAM port controls: fetch read on start, response writes in WRITE
    always_comb begin
        e_re    = (state == ENG_IDLE) && start && !abort;
        e_we    = (state == ENG_WRITE) && !abort;
        e_idx   = (state == ENG_WRITE) ? (base_q + widx) : ofs;
        e_wdata = resp_word(cmd0_q, op_q, 8'(widx));
        done    = (state == ENG_WRITE) && last_w && !abort;
    end

    // Sequencer: idle -> fetch -> run countdown -> response writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ENG_IDLE;
            cnt    <= '0;
            widx   <= '0;
            base_q <= '0;
            op_q   <= '0;
            cmd0_q <= '0;
        end else if (abort) begin
            state  <= ENG_IDLE;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (start) begin
                        state  <= ENG_FETCH;
                        op_q   <= op;
                        base_q <= ofs;
                    end
                end
                ENG_FETCH: begin
                    cmd0_q <= e_rdata;
                    cnt    <= CNT_TOP;
                    state  <= ENG_RUN;
                end
                ENG_RUN: begin
                    if (cnt == '0) begin
                        widx  <= '0;
                        state <= ENG_WRITE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ENG_WRITE: begin
                    if (last_w) begin
                        state <= ENG_IDLE;
                    end else begin
                        widx <= widx + 1'b1;
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/svc_mbox_regs.sv
// Register block: decodes the byte-addressed window, holds the control
// and status state (request, busy, abort, notify, latched command field,
// interrupt) and produces a one-cycle-late read word. RAM accesses are
// forwarded to the RAM host port. Assumes one strobe per cycle and that
// the RAM window fits in the address space.
module svc_mbox_regs
    import svc_mbox_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int WORDS  = 64,
    localparam int IDX_W = $clog2(WORDS),
    localparam int TAG_W = ADDR_W - IDX_W - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        reg_rdata,
    output logic               rd_ram_q,
    output logic               h_we,
    output logic               h_re,
    output logic [IDX_W-1:0]   h_idx,
    output logic [31:0]        h_wdata,
    input  logic               eng_done,
    output logic               eng_start,
    output logic               eng_abort,
    output logic [OP_W-1:0]    cmd_op,
    output logic [IDX_W-1:0]   cmd_ofs,
    output logic               req_st,
    output logic               busy_st,
    output logic               abort_st,
    output logic [FIELD_W-1:0] cmd_field,
    output logic               irq
);

    localparam logic [TAG_W-1:0]  RAM_TAG = TAG_W'(RAM_BASE >> (IDX_W + 2));
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(STAT_OFS);
    localparam logic [ADDR_W-1:0] A_ICLR  = ADDR_W'(IRQCLR_OFS);

    logic is_ctrl, is_stat, is_iclr, is_ram;
    logic accept, abort_req;
    logic notify_q;
    logic [31:0] ctrl_word, stat_word;

    // Address decode
    always_comb begin
        is_ctrl = (addr == A_CTRL);
        is_stat = (addr == A_STAT);
        is_iclr = (addr == A_ICLR);
        is_ram  = (addr[ADDR_W-1:IDX_W+2] == RAM_TAG);
    end

    // RAM host-port forwarding
    always_comb begin
        h_we    = wr_en && is_ram;
        h_re    = rd_en && is_ram;
        h_idx   = addr[IDX_W+1:2];
        h_wdata = wdata;
    end

    // Handshake events: new request when idle, abort when busy
    always_comb begin
        accept    = wr_en && is_ctrl && wdata[BIT_REQ]   && !busy_st;
        abort_req = wr_en && is_ctrl && wdata[BIT_ABORT] &&  busy_st;
    end

    // Control/status state and command latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_st    <= 1'b0;
            busy_st   <= 1'b0;
            abort_st  <= 1'b0;
            notify_q  <= 1'b0;
            cmd_field <= '0;
        end else begin
            req_st <= accept;
            if (accept) begin
                busy_st   <= 1'b1;
                abort_st  <= 1'b0;
                notify_q  <= wdata[BIT_NOTIFY];
                cmd_field <= wdata[FIELD_LSB +: FIELD_W];
            end else if (abort_req) begin
                busy_st   <= 1'b0;
                abort_st  <= 1'b1;
            end else if (eng_done) begin
                busy_st   <= 1'b0;
            end
        end
    end

    // Completion interrupt: set on notified completion, cleared by a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (eng_done && notify_q) begin
            irq <= 1'b1;
        end else if (wr_en && is_iclr) begin
            irq <= 1'b0;
        end
    end

    // Read-back words
    always_comb begin
        ctrl_word = {cmd_field, 12'h000, notify_q, 1'b0, 1'b0, req_st};
        stat_word = {cmd_field, 12'h000, irq, abort_st, busy_st, req_st};
    end

    // Registered read data and source select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
            rd_ram_q  <= 1'b0;
        end else begin
            rd_ram_q <= rd_en && is_ram;
            if (rd_en && is_ctrl) begin
                reg_rdata <= ctrl_word;
            end else if (rd_en && is_stat) begin
                reg_rdata <= stat_word;
            end else begin
                reg_rdata <= '0;
            end
        end
    end

    // Engine interface
    always_comb begin
        eng_start = req_st;
        eng_abort = abort_req;
        cmd_op    = cmd_field[OP_W-1:0];
        cmd_ofs   = cmd_field[OP_W +: IDX_W];
    end

endmodule

// File: rtl/svc_mailbox.sv
// Top of the service-request mailbox: register block, shared RAM and
// service-engine stub. Reads of registers and RAM both return data one
// cycle after the strobe. Assumes RAM_WORDS is a power of two and the
// RAM window lies inside the ADDR_W byte space.
module svc_mailbox
    import svc_mbox_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int RAM_WORDS  = 64,
    parameter int SVC_CYCLES = 8,
    parameter int RESP_WORDS = 4,
    localparam int IDX_W = $clog2(RAM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);

    logic               h_we, h_re;
    logic [IDX_W-1:0]   h_idx;
    logic [31:0]        h_wdata, h_rdata;
    logic               e_we, e_re;
    logic [IDX_W-1:0]   e_idx;
    logic [31:0]        e_wdata, e_rdata;
    logic [31:0]        reg_rdata;
    logic               rd_ram_q;
    logic               eng_start, eng_abort, eng_done;
    logic [OP_W-1:0]    cmd_op;
    logic [IDX_W-1:0]   cmd_ofs;
    logic               req_st, busy_st, abort_st;
    logic [FIELD_W-1:0] cmd_field;

    svc_mbox_regs #(
        .ADDR_W (ADDR_W),
        .WORDS  (RAM_WORDS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .rd_en     (bus_rd),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .reg_rdata (reg_rdata),
        .rd_ram_q  (rd_ram_q),
        .h_we      (h_we),
        .h_re      (h_re),
        .h_idx     (h_idx),
        .h_wdata   (h_wdata),
        .eng_done  (eng_done),
        .eng_start (eng_start),
        .eng_abort (eng_abort),
        .cmd_op    (cmd_op),
        .cmd_ofs   (cmd_ofs),
        .req_st    (req_st),
        .busy_st   (busy_st),
        .abort_st  (abort_st),
        .cmd_field (cmd_field),
        .irq       (irq)
    );

    svc_mbox_ram #(
        .WORDS (RAM_WORDS)
    ) u_ram (
        .clk     (clk),
        .h_we    (h_we),
        .h_re    (h_re),
        .h_idx   (h_idx),
        .h_wdata (h_wdata),
        .h_rdata (h_rdata),
        .e_we    (e_we),
        .e_re    (e_re),
        .e_idx   (e_idx),
        .e_wdata (e_wdata),
        .e_rdata (e_rdata)
    );

    svc_mbox_engine #(
        .WORDS      (RAM_WORDS),
        .SVC_CYCLES (SVC_CYCLES),
        .RESP_WORDS (RESP_WORDS)
    ) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (eng_start),
        .abort   (eng_abort),
        .op      (cmd_op),
        .ofs     (cmd_ofs),
        .e_re    (e_re),
        .e_we    (e_we),
        .e_idx   (e_idx),
        .e_wdata (e_wdata),
        .e_rdata (e_rdata),
        .done    (eng_done)
    );

    // Read data source: RAM or register word, chosen by the registered select
    always_comb begin
        bus_rdata = rd_ram_q ? h_rdata : reg_rdata;
    end

endmodule

// File: rtl/svc_mailbox_chk.sv
// Checker for the service-request mailbox, bound to the top module.
// Observes the handshake state, the engine write strobe and the interrupt.
module svc_mailbox_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_st,
    input logic        busy_st,
    input logic        abort_st,
    input logic        irq,
    input logic        e_we,
    input logic [15:0] cmd_field
);

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_st |=> !req_st);                                                  // R4

    AST_REQ_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        req_st |-> busy_st);                                                  // R4

    AST_CMD_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_st && $past(busy_st)) |-> $stable(cmd_field));                  // R9

    AST_RESP_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        e_we |-> busy_st);                                                    // R5

    AST_IRQ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(busy_st) && !busy_st && !abort_st));            // R6

    AST_ABORT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abort_st) |-> (!busy_st && !$rose(irq)));                       // R8

endmodule

bind svc_mailbox svc_mailbox_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_st    (req_st),
    .busy_st   (busy_st),
    .abort_st  (abort_st),
    .irq       (irq),
    .e_we      (e_we),
    .cmd_field (cmd_field)
);

// File: tb/tb_svc_mailbox.sv
// Bench for svc_mailbox: a table of RAM write/read-back vectors, then
// directed handshake, interrupt, abort and wrap cases.
module tb_svc_mailbox;

    localparam int ADDR_W = 12;
    localparam logic [11:0] A_CTRL = 12'h050;
    localparam logic [11:0] A_STAT = 12'h054;
    localparam logic [11:0] A_ICLR = 12'h058;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done_all = 1'b0;

    svc_mailbox #(
        .ADDR_W     (ADDR_W),
        .RAM_WORDS  (64),
        .SVC_CYCLES (8),
        .RESP_WORDS (4)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #10 clk = ~clk;   // 50 MHz

    // {address, data}: RAM write vectors, read back afterwards (R2)
    localparam logic [43:0] VEC [8] = '{
        {12'h800, 32'hDEAD_BEEF}, {12'h804, 32'h0000_0001},
        {12'h808, 32'h8000_0000}, {12'h8FC, 32'hA5A5_5A5A},
        {12'h880, 32'h1357_9BDF}, {12'h884, 32'hFFFF_FFFF},
        {12'h8F8, 32'h0F0F_00FF}, {12'h840, 32'h2468_ACE0}
    };

    // Caller is at a negedge; each task ends at a negedge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] waddr(input int i);
        return 12'h800 + 12'((i % 64) * 4);
    endfunction

    function automatic logic [31:0] cmdw(input int ofs, input logic [6:0] op,
                                         input logic [3:0] bits);
        return {9'(ofs), op, 12'h000, bits};
    endfunction

    function automatic logic [31:0] exp_resp(input logic [31:0] c, input logic [6:0] op,
                                             input int k);
        return c ^ {8'(k), 1'b0, op, 16'h5A5A};
    endfunction

    task automatic wait_idle(input string req);
        logic [31:0] s;
        int n = 0;
        s = 32'h2;
        while (s[1] && n < 200) begin
            rd(A_STAT, s);
            n++;
        end
        if (s[1]) chk(req, s, {s[31:2], 1'b0, s[0]});
    endtask

    task automatic chk_resp(input string req, input int ofs, input logic [31:0] c,
                            input logic [6:0] op);
        logic [31:0] v;
        for (int k = 0; k < 4; k++) begin
            rd(waddr(ofs + k), v);
            chk(req, v, exp_resp(c, op, k));
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done_all) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(A_STAT, v); chk("R1 status", v, 32'h0);
        rd(A_CTRL, v); chk("R1 control", v, 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);

        // R2: table walk, write then read back
        foreach (VEC[i]) wr(VEC[i][43:32], VEC[i][31:0]);
        foreach (VEC[i]) begin
            rd(VEC[i][43:32], v);
            chk("R2 ram readback", v, VEC[i][31:0]);
        end
        // R2: byte merge by read-modify-write
        rd(12'h804, v);
        wr(12'h804, {v[31:8], 8'hC7});
        rd(12'h804, v); chk("R2 byte merge", v, 32'h0000_00C7);

        // R3/R4/R5/R6: notified service at offset 10
        wr(waddr(10), 32'h1234_5678);
        wr(waddr(14), 32'h7777_0000);
        wr(A_CTRL, cmdw(10, 7'h15, 4'b1001));
        rd(A_STAT, v); chk("R4 req+busy first cycle", v, {9'd10, 7'h15, 16'h0003});
        rd(A_STAT, v); chk("R4 req cleared busy held", v, {9'd10, 7'h15, 16'h0002});
        rd(A_CTRL, v); chk("R3 control readback", v, {9'd10, 7'h15, 16'h0008});
        wait_idle("R5 busy clears");
        rd(A_STAT, v); chk("R6 status notify", v, {9'd10, 7'h15, 16'h0008});
        chk("R6 irq high", 32'(irq), 32'h1);
        chk_resp("R5 response words", 10, 32'h1234_5678, 7'h15);
        rd(waddr(14), v); chk("R5 word past window", v, 32'h7777_0000);

        // R7: interrupt clear
        wr(A_ICLR, 32'h0);
        chk("R7 irq low", 32'(irq), 32'h0);
        rd(A_STAT, v); chk("R7 status bit3", 32'(v[3]), 32'h0);

        // R5/R6: no notify, wrap at top of RAM
        wr(waddr(62), 32'hCAFE_F00D);
        wr(A_CTRL, cmdw(62, 7'h22, 4'b0001));
        wait_idle("R5 wrap busy");
        chk("R6 no irq", 32'(irq), 32'h0);
        chk_resp("R5 wrap response", 62, 32'hCAFE_F00D, 7'h22);

        // R9: second request while busy ignored
        wr(waddr(20), 32'h0BAD_F00D);
        wr(waddr(30), 32'h3030_3030);
        wr(A_CTRL, cmdw(20, 7'h11, 4'b1001));
        wr(A_CTRL, cmdw(30, 7'h33, 4'b1001));
        rd(A_STAT, v); chk("R9 field kept", 32'(v[31:16]), 32'({9'd20, 7'h11}));
        wait_idle("R9 busy");
        chk_resp("R9 original command", 20, 32'h0BAD_F00D, 7'h11);
        rd(waddr(30), v); chk("R9 second offset untouched", v, 32'h3030_3030);
        wr(A_ICLR, 32'h0);

        // R8: abort mid-service
        wr(waddr(40), 32'h4040_4040);
        wr(waddr(41), 32'h4141_4141);
        wr(A_CTRL, cmdw(40, 7'h05, 4'b1001));
        rd(A_STAT, v);
        wr(A_CTRL, 32'h0000_0004);
        rd(A_STAT, v); chk("R8 busy clear abort set", v, {9'd40, 7'h05, 16'h0004});
        repeat (30) @(negedge clk);
        chk("R8 no irq", 32'(irq), 32'h0);
        rd(waddr(40), v); chk("R8 no response w0", v, 32'h4040_4040);
        rd(waddr(41), v); chk("R8 no response w1", v, 32'h4141_4141);

        // R10: abort while idle ignored, then cleared by next request
        wr(A_CTRL, 32'h0000_0004);
        rd(A_STAT, v); chk("R10 idle abort no effect", v, {9'd40, 7'h05, 16'h0004});
        wr(A_CTRL, cmdw(50, 7'h01, 4'b0001));
        rd(A_STAT, v); chk("R10 abort cleared", v, {9'd50, 7'h01, 16'h0003});
        wait_idle("R10 busy");

        done_all = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule